// File: doc/BRIEF.md
# Quadrature Position Decoder with Index Reload

This block turns the two phase-shifted channels of an incremental encoder into a signed 32-bit position. The resolution is chosen per run: one count per full encoder cycle, two counts (every edge of channel A), or four counts (every edge of either channel). The direction of each count follows the order in which the channels move. When the encoder's index channel is high while both A and B are low, the position can be forced to a programmed value. A control bit turns this reload on or off.

The position reaches the outside in one of three capture styles. In single style, a snapshot register follows every change of the count. In sampled style, the count is written into a result FIFO on each rising level of a sample strobe. In event style, every count change pushes the new count into the FIFO. The A, B, Z and strobe inputs must already be synchronized to `clk`. The decoder compares each input sample with the sample from the previous cycle.

Top module: `qdec_index_top`

## Requirements
- R1: With `enc_mode` = 0, the count changes only when A rises. It goes up by one if B is low at that moment and down by one if B is high.
- R2: With `enc_mode` = 1, every edge of A counts. The count goes up when the new A differs from B and down when they are equal.
- R3: With `enc_mode` = 2 or 3, every edge of A counts as in R2. Every edge of B also counts, going up when the new A equals the new B and down otherwise.
- R4: If A and B both change between two consecutive samples, the count does not change and `seq_err` goes high. `seq_err` stays high until reset.
- R5: With `rld_en` = 1, the count is loaded with `rld_val` once, in the cycle where the condition (Z=1, A=0, B=0) first becomes true. A step in the same cycle is discarded. Holding the condition does not load again.
- R6: With `rld_en` = 0, Z has no effect on the count.
- R7: The count is 32-bit two's complement and wraps: 0x7FFFFFFF plus one is 0x80000000.
- R8: With `cap_mode` = 0 or 3 (single), `snap_o` takes the new count on every step or reload, and nothing is written to the FIFO. In other modes `snap_o` holds its value.
- R9: With `cap_mode` = 1 (sampled), a sample with `smp_clk` = 1 after one with `smp_clk` = 0 writes the count as it stood before that cycle's update.
- R10: With `cap_mode` = 2 (event), every step or reload writes the new count.
- R11: The FIFO holds 8 entries and shows its oldest entry on `fifo_dout` while `fifo_nempty` is high. `rd_en` removes that entry. A write is dropped when `fifo_full` is high.
- R12: After reset the count, `snap_o` and `seq_err` are zero and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder channel A, synchronized |
| enc_b | input | 1 | Encoder channel B, synchronized |
| enc_z | input | 1 | Index channel, synchronized |
| enc_mode | input | 2 | 0 = x1, 1 = x2, 2/3 = x4 |
| cap_mode | input | 2 | 0/3 = single, 1 = sampled, 2 = event |
| rld_en | input | 1 | Enables the index reload |
| rld_val | input | 32 | Value loaded on index |
| smp_clk | input | 1 | Sample strobe level for sampled capture |
| rd_en | input | 1 | Removes the FIFO head entry |
| snap_o | output | 32 | Single-style count snapshot |
| fifo_dout | output | 32 | FIFO head entry |
| fifo_nempty | output | 1 | FIFO holds at least one entry |
| fifo_full | output | 1 | FIFO holds 8 entries |
| seq_err | output | 1 | Sticky flag for a simultaneous A/B change |

## Verification
Every result is due at the first clock edge that samples the new input levels. This covers the count update, `snap_o`, `seq_err` and the FIFO write. The FIFO head, `fifo_nempty` and `fifo_full` are therefore visible right after that edge. A pop by `rd_en` shows its effect after the edge that samples it. The bench drives inputs 2 ns after a rising edge, advances one edge, and then compares the outputs against its own model before it drives again. FIFO reads happen only while the encoder inputs and the strobe are held, so a pop never coincides with a write.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam logic [1:0] ENC_X1 = 2'd0;
  localparam logic [1:0] CAP_SAMPLED = 2'd1;
  localparam logic [1:0] CAP_EVENT = 2'd2;

  // Signed step: 2'b01 = +1, 2'b11 = -1, 2'b00 = none
  function automatic logic [1:0] qd_step(input logic [1:0] mode,
                                         input logic pa, input logic pb,
                                         input logic a, input logic b);
    logic a_moved, b_moved;
    logic [1:0] st;
    a_moved = pa ^ a;
    b_moved = pb ^ b;
    st = 2'b00;
    if (a_moved && !b_moved) begin
      if (mode == ENC_X1) begin
        if (a) st = b ? 2'b11 : 2'b01;
      end else begin
        st = (a ^ b) ? 2'b01 : 2'b11;
      end
    end else if (b_moved && !a_moved && mode[1]) begin
      st = (a == b) ? 2'b01 : 2'b11;
    end
    return st;
  endfunction

  function automatic logic in_index_phase(input logic z, input logic a, input logic b);
    return z & ~a & ~b;
  endfunction
endpackage

// File: rtl/qdec_edge.sv
module qdec_edge
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a,
  input  logic       b,
  input  logic       z,
  input  logic [1:0] mode,
  output logic [1:0] step,
  output logic       illegal,
  output logic       idx_entry
);
  logic pa, pb, pz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa <= 1'b0;
      pb <= 1'b0;
      pz <= 1'b0;
    end else begin
      pa <= a;
      pb <= b;
      pz <= z;
    end
  end

  assign step      = qd_step(mode, pa, pb, a, b);
  assign illegal   = (pa ^ a) & (pb ^ b);
  assign idx_entry = in_index_phase(z, a, b) & ~in_index_phase(pz, pa, pb);
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   step,
  input  logic         illegal,
  input  logic         idx_entry,
  input  logic         rld_en,
  input  logic [W-1:0] rld_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next,
  output logic         cnt_evt,
  output logic         seq_err
);
  logic reload_fire;
  logic [W-1:0] step_ext;

  assign reload_fire = rld_en & idx_entry;
  assign step_ext    = {{(W-2){step[1]}}, step};
  assign cnt_next    = reload_fire ? rld_val : cnt + step_ext;
  assign cnt_evt     = reload_fire | (step != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      seq_err <= 1'b0;
    end else begin
      cnt <= cnt_next;
      if (illegal) seq_err <= 1'b1;
    end
  end

  // R5
  reload_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> cnt == $past(rld_val));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  // R4
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !reload_fire) |=> $stable(cnt));
endmodule

// File: rtl/qdec_capture.sv
module qdec_capture
  import qdec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cap_mode,
  input  logic         smp_clk,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cnt_next,
  input  logic         cnt_evt,
  output logic         push,
  output logic [W-1:0] push_data,
  output logic [W-1:0] snap
);
  logic smp_q;
  logic smp_rise;
  logic single_sel;

  assign smp_rise   = smp_clk & ~smp_q;
  assign single_sel = (cap_mode != CAP_SAMPLED) && (cap_mode != CAP_EVENT);

  always_comb begin
    push      = 1'b0;
    push_data = cnt_next;
    if (cap_mode == CAP_SAMPLED) begin
      push      = smp_rise;
      push_data = cnt;
    end else if (cap_mode == CAP_EVENT) begin
      push = cnt_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      snap  <= '0;
    end else begin
      smp_q <= smp_clk;
      if (single_sel && cnt_evt) snap <= cnt_next;
    end
  end
endmodule

// File: rtl/qdec_fifo.sv
module qdec_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nempty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   occ;
  logic          do_wr, do_rd;

  assign full   = (occ == DEPTH_C);
  assign nempty = (occ != '0);
  assign do_wr  = push & ~full;
  assign do_rd  = pop & nempty;
  assign dout   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      occ <= occ + {{AW{1'b0}}, do_wr} - {{AW{1'b0}}, do_rd};
    end
  end

  // R11
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_C);
  // R11
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/qdec_index_top.sv
module qdec_index_top
  import qdec_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enc_a,
  input  logic         enc_b,
  input  logic         enc_z,
  input  logic [1:0]   enc_mode,
  input  logic [1:0]   cap_mode,
  input  logic         rld_en,
  input  logic [W-1:0] rld_val,
  input  logic         smp_clk,
  input  logic         rd_en,
  output logic [W-1:0] snap_o,
  output logic [W-1:0] fifo_dout,
  output logic         fifo_nempty,
  output logic         fifo_full,
  output logic         seq_err
);
  logic [1:0]   step;
  logic         illegal, idx_entry, cnt_evt, push;
  logic [W-1:0] cnt, cnt_next, push_data;

  qdec_edge u_edge (
    .clk(clk), .rst_n(rst_n), .a(enc_a), .b(enc_b), .z(enc_z), .mode(enc_mode),
    .step(step), .illegal(illegal), .idx_entry(idx_entry)
  );

  qdec_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .illegal(illegal), .idx_entry(idx_entry),
    .rld_en(rld_en), .rld_val(rld_val), .cnt(cnt), .cnt_next(cnt_next),
    .cnt_evt(cnt_evt), .seq_err(seq_err)
  );

  qdec_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .smp_clk(smp_clk), .cnt(cnt),
    .cnt_next(cnt_next), .cnt_evt(cnt_evt), .push(push), .push_data(push_data),
    .snap(snap_o)
  );

  qdec_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_data), .pop(rd_en),
    .dout(fifo_dout), .nempty(fifo_nempty), .full(fifo_full)
  );

  // R10
  event_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == CAP_EVENT && cnt_evt) |-> push);
  // R8
  single_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'd0 || cap_mode == 2'd3) |-> !push);
endmodule

// File: tb/qdec_index_top_tb.sv
module qdec_index_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 0, b = 0, z = 0, s = 0, rd_en = 0, rld_en = 0;
  logic [1:0] enc_mode = 2'd2, cap_mode = 2'd0;
  logic [31:0] rld_val = '0;
  logic [31:0] snap_o, fifo_dout;
  logic fifo_nempty, fifo_full, seq_err;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_cnt = '0, m_snap = '0;
  logic m_err = 1'b0;
  logic pa = 0, pb = 0, pz = 0, ps = 0;
  logic [31:0] q[$];

  always #4 clk = ~clk;

  qdec_index_top u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(a), .enc_b(b), .enc_z(z), .enc_mode(enc_mode),
    .cap_mode(cap_mode), .rld_en(rld_en), .rld_val(rld_val), .smp_clk(s),
    .rd_en(rd_en), .snap_o(snap_o), .fifo_dout(fifo_dout), .fifo_nempty(fifo_nempty),
    .fifo_full(fifo_full), .seq_err(seq_err)
  );

  function automatic int gidx(logic ga, logic gb);
    return ga ? (gb ? 2 : 1) : (gb ? 3 : 0);
  endfunction

  // Count delta from position on the gray cycle 00,10,11,01
  function automatic int model_step(logic [1:0] md, logic oa, logic ob, logic na, logic nb);
    int d, dir;
    d = (gidx(na, nb) - gidx(oa, ob) + 4) % 4;
    if (d == 0 || d == 2) return 0;
    dir = (d == 1) ? 1 : -1;
    if (md >= 2) return dir;
    if (oa == na) return 0;
    if (md == 1) return dir;
    return na ? dir : 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(logic na, logic nb, logic nz, logic ns);
    int st;
    logic reload, evt, single;
    logic [31:0] old_cnt;
    a = na; b = nb; z = nz; s = ns;
    cyc();
    old_cnt = m_cnt;
    st = 0;
    if (pa != na && pb != nb) m_err = 1'b1;
    else st = model_step(enc_mode, pa, pb, na, nb);
    reload = rld_en && (nz && !na && !nb) && !(pz && !pa && !pb);
    if (reload) m_cnt = rld_val;
    else m_cnt = m_cnt + st;
    evt = reload || st != 0;
    single = (cap_mode == 0 || cap_mode == 3);
    if (single && evt) m_snap = m_cnt;
    if (cap_mode == 2 && evt && q.size() < 8) q.push_back(m_cnt);
    if (cap_mode == 1 && ns && !ps && q.size() < 8) q.push_back(old_cnt);
    pa = na; pb = nb; pz = nz; ps = ns;
  endtask

  task automatic check_outs(string tag);
    check({tag, " snap"}, snap_o, m_snap);
    check({tag, " err R4"}, {31'd0, seq_err}, {31'd0, m_err});
    check({tag, " full R11"}, {31'd0, fifo_full}, {31'd0, q.size() == 8});
    check({tag, " nempty R11"}, {31'd0, fifo_nempty}, {31'd0, q.size() != 0});
  endtask

  task automatic drain(string tag);
    while (q.size() > 0) begin
      check({tag, " head"}, fifo_dout, q[0]);
      check({tag, " nempty R11"}, {31'd0, fifo_nempty}, 32'd1);
      rd_en = 1'b1;
      cyc();
      rd_en = 1'b0;
      void'(q.pop_front());
    end
    check({tag, " drained R11"}, {31'd0, fifo_nempty}, 32'd0);
  endtask

  task automatic walk(int dir, int n);
    for (int i = 0; i < n; i++) begin
      int k;
      k = (gidx(pa, pb) + dir + 4) % 4;
      drive(k == 1 || k == 2, k == 2 || k == 3, z, s);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R12 reset state
    check("R12 snap", snap_o, 32'd0);
    check("R12 nempty", {31'd0, fifo_nempty}, 32'd0);
    check("R12 err", {31'd0, seq_err}, 32'd0);

    enc_mode = 2'd2; walk(1, 8);
    check("R3 x4 forward", snap_o, 32'd8);
    walk(-1, 4);
    check("R3 x4 reverse", snap_o, 32'd4);
    enc_mode = 2'd1; walk(1, 4);
    check("R2 x2 cycle", snap_o, 32'd6);
    enc_mode = 2'd0; walk(1, 4);
    check("R1 x1 forward", snap_o, 32'd7);
    walk(-1, 4);
    check("R1 x1 reverse", snap_o, 32'd6);
    check_outs("R8 single");

    enc_mode = 2'd2;
    drive(~pa, ~pb, 1'b0, 1'b0);
    check("R4 illegal count", snap_o, 32'd6);
    check("R4 illegal err", {31'd0, seq_err}, 32'd1);
    walk(1, 1);
    check("R4 sticky", {31'd0, seq_err}, 32'd1);

    rld_en = 1'b1; rld_val = 32'h7FFF_FFFF;
    while (pa || pb) walk(1, 1);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    check("R5 reload", snap_o, 32'h7FFF_FFFF);
    cap_mode = 2'd2;
    drive(0, 0, 1, 0); drive(0, 0, 1, 0); drive(0, 0, 1, 0);
    check("R5 once nempty", {31'd0, fifo_nempty}, 32'd0);
    drive(0, 0, 0, 0);
    walk(1, 1);
    check("R7 wrap head", fifo_dout, 32'h8000_0000);
    drain("R10 event");

    rld_en = 1'b0;
    while (pa || pb) walk(1, 1);
    drain("R10 pre R6");
    drive(0, 0, 1, 0); drive(0, 0, 0, 0);
    check("R6 z ignored nempty", {31'd0, fifo_nempty}, 32'd0);

    cap_mode = 2'd1;
    walk(1, 3); drive(pa, pb, 0, 1); walk(1, 2); drive(pa, pb, 0, 0); drive(pa, pb, 0, 1);
    check_outs("R9 sampled");
    drain("R9 sampled");

    cap_mode = 2'd2;
    walk(-1, 11);
    check("R11 full", {31'd0, fifo_full}, 32'd1);
    drain("R11 overflow");

    for (int blk = 0; blk < 30; blk++) begin
      enc_mode = 2'($urandom % 4);
      cap_mode = 2'($urandom % 4);
      rld_en = 1'($urandom % 2);
      rld_val = $urandom;
      for (int it = 0; it < 25; it++) begin
        int r;
        r = $urandom % 100;
        if (r < 70) walk(($urandom % 2) ? 1 : -1, 1);
        else if (r < 80) drive(pa, pb, ~z, s);
        else if (r < 83) drive(~pa, ~pb, z, s);
        else drive(pa, pb, z, ~s);
        check_outs("R1 R2 R3 R5 random");
      end
      drain("R9 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule